// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block is a register-driven master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software programs a clock divider and an enable bit in a control register. It then starts a single read or write transaction by writing a command word with its start bit set. The block derives MDC from the system clock. It shifts out a full clause 22 frame most significant bit first and, on reads, releases the data line so the PHY can drive the turnaround and the 16 data bits back.

The start bit stays set while the frame is on the wire and clears by itself when the frame ends. Software polls that bit, or the idle flag in the control register, to know when the result is valid. A completed read leaves the returned data in the low half of the command register. It also leaves a response flag that tells whether the PHY pulled the line low in the second turnaround slot. Command writes that arrive while a frame is running are dropped.

The frame engine is a five-state machine that advances only on MDC falling edges:
- IDLE→PREAMBLE when a command is pending.
- PREAMBLE (32 ones)→HEADER.
- HEADER (start, opcode, PHY address, register address; 14 bits)→TURN.
- TURN (2 bits)→DATA.
- DATA (16 bits)→IDLE, which completes the command.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 32'h8000_0000 (idle flag bit 31 set, enable bit 30 clear, divider zero), the command register reads zero, MDC is low and the MDIO output enable is low.
- R2: While enable (control bit 30) is set, MDC has a period of 2*(divider+1) system clocks, with the divider in control bits DIV_W-1:0. While enable is clear, MDC stays low.
- R3: Writing the command register with bit 31 (start) set begins a frame. Bit 31 reads 1 and the control idle flag (bit 31) reads 0 until the frame ends, then bit 31 reads 0.
- R4: A write command (bit 30 = 1) sends 64 bits MSB first: 32 ones, 01, opcode 01, the PHY address (command bits 20:16), the register address (command bits 25:21), turnaround 10, then command bits 15:0. The output enable is high for every bit.
- R5: MDIO output changes only while MDC is low (after a falling edge), never while MDC is high.
- R6: A read command (bit 30 = 0) sends opcode 10 and releases the output enable for the two turnaround bits and the 16 data bits. The 16 bits sampled on MDC rising edges are placed MSB first in command bits 15:0 when the frame ends.
- R7: After a read, command bit 29 is 1 exactly when MDIO was low at the MDC rising edge of the second turnaround bit. It is cleared when a new command is accepted, and it is 0 after a write frame.
- R8: A command-register write while bit 31 is still set has no effect on the running frame or on the register contents.
- R9: The MDIO output enable is low whenever no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register select: 0 control, 1 command |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Data sampled from MDIO |

## Verification
A state machine stuck in or skipping a phase shows at the pins within one MDC period. The frame then has the wrong bit count, the enable is released in the wrong slot, or the start bit never clears. Bit-by-bit comparison of every frame against the expected pattern catches these errors. A wrong sampling point shows up only as wrong read data or a wrong response flag in the command register at the end of the frame. For this reason reads are run both with a responding PHY and with a silent one. A dropped-write fault appears at once in the command register readback and, one frame later, as a corrupted frame on the wire.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TURN_BITS  = 2;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TURN_BITS + DATA_BITS;
    localparam int LEFT_W     = $clog2(PRE_BITS);

    localparam int CMD_START  = 31;
    localparam int CMD_WRITE  = 30;
    localparam int CMD_ACK    = 29;
    localparam int CTL_IDLE   = 31;
    localparam int CTL_EN     = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } frame_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap      = en && (cnt_q >= div);
    assign rise_tick = wrap && !mdc_q;
    assign fall_tick = wrap && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MDC_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc); // R2
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 is_write,
    input  logic [4:0]           phy_addr,
    input  logic [4:0]           reg_addr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 active,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 ack
);
    frame_state_e           state_q, state_d;
    logic [LEFT_W-1:0]      left_q, left_d;
    logic [FRAME_BITS-1:0]  sreg_q, sreg_d;
    logic [FRAME_BITS-1:0]  frame;
    logic [FRAME_BITS-1:0]  shifted;
    logic                   last_bit;

    assign frame    = {{PRE_BITS{1'b1}}, 2'b01, (is_write ? 2'b01 : 2'b10),
                       phy_addr, reg_addr, 2'b10, wdata};
    assign shifted  = {sreg_q[FRAME_BITS-2:0], 1'b0};
    assign last_bit = (left_q == '0);

    // next-state process
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        sreg_d  = sreg_q;
        if (fall_tick) begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_d = ST_PREAMBLE;
                    left_d  = LEFT_W'(PRE_BITS - 1);
                    sreg_d  = frame;
                end
                ST_PREAMBLE: begin
                    sreg_d = shifted;
                    if (last_bit) begin
                        state_d = ST_HEADER;
                        left_d  = LEFT_W'(HDR_BITS - 1);
                    end else left_d = left_q - 1'b1;
                end
                ST_HEADER: begin
                    sreg_d = shifted;
                    if (last_bit) begin
                        state_d = ST_TURN;
                        left_d  = LEFT_W'(TURN_BITS - 1);
                    end else left_d = left_q - 1'b1;
                end
                ST_TURN: begin
                    sreg_d = shifted;
                    if (last_bit) begin
                        state_d = ST_DATA;
                        left_d  = LEFT_W'(DATA_BITS - 1);
                    end else left_d = left_q - 1'b1;
                end
                ST_DATA: begin
                    sreg_d = shifted;
                    if (last_bit) state_d = ST_IDLE;
                    else          left_d  = left_q - 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            sreg_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            sreg_q  <= sreg_d;
        end
    end

    // output process
    always_comb begin
        active  = (state_q != ST_IDLE);
        mdio_o  = sreg_q[FRAME_BITS-1];
        mdio_oe = active && (is_write || state_q == ST_PREAMBLE || state_q == ST_HEADER);
        done    = fall_tick && (state_q == ST_DATA) && last_bit;
    end

    // read capture on MDC rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            ack   <= 1'b0;
        end else if (fall_tick && state_q == ST_IDLE && start) begin
            ack <= 1'b0;
        end else if (rise_tick && !is_write) begin
            if (state_q == ST_TURN && last_bit) ack <= !mdio_i;
            if (state_q == ST_DATA) rdata <= {rdata[DATA_BITS-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_CMD  = 1'b1;
    localparam int   PAD_W    = 30 - DIV_W;

    logic             en_q;
    logic [DIV_W-1:0] div_q;
    logic             busy_q, wr_q, ack_q;
    logic [4:0]       phy_q, regad_q;
    logic [15:0]      data_q;

    logic             rise_tick, fall_tick;
    logic             fsm_active, fsm_done, fsm_ack;
    logic [15:0]      fsm_rdata;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[28:26];

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (busy_q),
        .is_write  (wr_q),
        .phy_addr  (phy_q),
        .reg_addr  (regad_q),
        .wdata     (data_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .active    (fsm_active),
        .done      (fsm_done),
        .rdata     (fsm_rdata),
        .ack       (fsm_ack)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            div_q   <= '0;
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            ack_q   <= 1'b0;
            phy_q   <= '0;
            regad_q <= '0;
            data_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == SEL_CTRL) begin
                en_q  <= reg_wdata[CTL_EN];
                div_q <= reg_wdata[DIV_W-1:0];
            end
            if (busy_q) begin
                if (fsm_done) begin
                    busy_q <= 1'b0;
                    ack_q  <= !wr_q && fsm_ack;
                    if (!wr_q) data_q <= fsm_rdata;
                end
            end else if (reg_wr && reg_addr == SEL_CMD) begin
                busy_q  <= reg_wdata[CMD_START];
                wr_q    <= reg_wdata[CMD_WRITE];
                regad_q <= reg_wdata[25:21];
                phy_q   <= reg_wdata[20:16];
                data_q  <= reg_wdata[15:0];
                if (reg_wdata[CMD_START]) ack_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (reg_addr == SEL_CTRL)
            reg_rdata = {(!busy_q && !fsm_active), en_q, {PAD_W{1'b0}}, div_q};
        else
            reg_rdata = {busy_q, wr_q, ack_q, 3'b000, regad_q, phy_q, data_q};
    end

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !fsm_done |=> busy_q); // R3
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && reg_wr && reg_addr == SEL_CMD && !fsm_done
        |=> $stable(phy_q) && $stable(regad_q) && $stable(wr_q) && $stable(data_q)); // R8
    AST_NO_DRIVE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mdio_oe); // R9
    AST_MDIO_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o)); // R5
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        string       tag;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    frame_t exp_q[$];
    int     frames_pushed = 0;
    int     frames_seen = 0;

    logic [15:0] phy_resp = '0;
    logic        phy_ack = 1'b0;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cmd_done(output logic [31:0] d);
        do reg_read(1'b1, d); while (d[31]);
    endtask

    function automatic frame_t make_frame(input bit wr, input logic [4:0] phy,
                                          input logic [4:0] ra, input logic [15:0] dat,
                                          input string tag);
        frame_t f;
        f.bits = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, dat};
        f.oe   = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
        f.tag  = tag;
        return f;
    endfunction

    // driver: push expectation, issue command
    task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] dat, input string tag);
        exp_q.push_back(make_frame(wr, phy, ra, dat, tag));
        frames_pushed++;
        reg_write(1'b1, {1'b1, wr, 1'b0, 3'b000, ra, phy, dat});
    endtask

    // monitor: collect frames at MDC rising edges, compare against queue
    logic [63:0] cap_bits, cap_oe;
    int          idx = 0;
    bit          in_frame = 1'b0;

    always @(posedge mdc) begin
        #1;
        if (!in_frame && mdio_oe) begin
            in_frame = 1'b1;
            idx = 0;
        end
        if (in_frame) begin
            cap_bits[63-idx] = mdio_o;
            cap_oe[63-idx]   = mdio_oe;
            idx++;
            if (idx == 64) begin
                in_frame = 1'b0;
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame", cap_bits, 64'h0);
                end else begin
                    frame_t e;
                    e = exp_q.pop_front();
                    check(cap_oe == e.oe, {e.tag, " output enable pattern"}, cap_oe, e.oe);
                    check((cap_bits & e.oe) == (e.bits & e.oe), {e.tag, " frame bits"},
                          cap_bits & e.oe, e.bits & e.oe);
                end
                idx = 0;
            end
        end
    end

    // PHY model: drives turnaround and data on reads after falling edges
    always @(negedge mdc) begin
        #1;
        if (in_frame && idx >= 46 && cap_bits[29:28] == 2'b10) begin
            if (idx == 46)       mdio_i = 1'b1;
            else if (idx == 47)  mdio_i = phy_ack ? 1'b0 : 1'b1;
            else                 mdio_i = phy_ack ? phy_resp[63-idx] : 1'b1;
        end else begin
            mdio_i = 1'b1;
        end
    end

    // R5: output must not change while MDC is high
    int   hold_viol = 0;
    logic prev_o = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mdc && mdio_oe && mdio_o != prev_o) hold_viol++;
        prev_o = mdio_o;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        time t1, t2;
        bit stayed_low;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        reg_read(1'b0, d);
        check(d == 32'h8000_0000, "R1 control after reset", d, 32'h8000_0000);
        reg_read(1'b1, d);
        check(d == 32'h0, "R1 command after reset", d, 32'h0);
        check(!mdc && !mdio_oe, "R1 pins after reset", {mdc, mdio_oe}, 2'b00);

        // R2 disabled: MDC stays low
        stayed_low = 1'b1;
        repeat (30) @(negedge clk) if (mdc) stayed_low = 1'b0;
        check(stayed_low, "R2 MDC low while disabled", mdc, 1'b0);

        // R2 period with divider 0 and 3
        reg_write(1'b0, 32'h4000_0000);
        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        check((t2 - t1) == 2 * CLK_PERIOD, "R2 period div0", t2 - t1, 2 * CLK_PERIOD);
        reg_write(1'b0, 32'h4000_0003);
        @(posedge mdc);
        @(posedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        check((t2 - t1) == 8 * CLK_PERIOD, "R2 period div3", t2 - t1, 8 * CLK_PERIOD);

        // R4 write frame, R3 start flag behaviour
        reg_write(1'b0, 32'h4000_0001);
        issue(1'b1, 5'h05, 5'h09, 16'hA5C3, "R4 write");
        repeat (20) @(posedge clk);
        reg_read(1'b1, d);
        check(d[31] == 1'b1, "R3 start bit held mid-frame", d[31], 1'b1);
        reg_read(1'b0, d);
        check(d[31] == 1'b0, "R3 idle flag clear mid-frame", d[31], 1'b0);
        wait_cmd_done(d);
        check(d == {3'b010, 3'b000, 5'h09, 5'h05, 16'hA5C3}, "R3 command after write frame",
              d, {3'b010, 3'b000, 5'h09, 5'h05, 16'hA5C3});
        check(d[29] == 1'b0, "R7 response flag zero after write", d[29], 1'b0);
        reg_read(1'b0, d);
        check(d[31] == 1'b1, "R3 idle flag set after frame", d[31], 1'b1);
        check(!mdio_oe, "R9 enable low after frame", mdio_oe, 1'b0);

        // R6/R7 read with responding PHY
        phy_resp = 16'hBEEF;
        phy_ack  = 1'b1;
        issue(1'b0, 5'h11, 5'h02, 16'h0000, "R6 read ack");
        wait_cmd_done(d);
        check(d[15:0] == 16'hBEEF, "R6 read data", d[15:0], 16'hBEEF);
        check(d[29] == 1'b1, "R7 response flag with PHY", d[29], 1'b1);

        // second pattern with divider 0
        reg_write(1'b0, 32'h4000_0000);
        phy_resp = 16'h1234;
        issue(1'b0, 5'h1F, 5'h1F, 16'h0000, "R6 read pattern2");
        wait_cmd_done(d);
        check(d[15:0] == 16'h1234, "R6 read data div0", d[15:0], 16'h1234);

        // R7 silent PHY
        phy_ack = 1'b0;
        issue(1'b0, 5'h03, 5'h10, 16'h0000, "R6 read silent");
        wait_cmd_done(d);
        check(d[29] == 1'b0, "R7 response flag silent PHY", d[29], 1'b0);
        check(d[15:0] == 16'hFFFF, "R6 read data from idle line", d[15:0], 16'hFFFF);

        // R8 command write during a frame is dropped
        reg_write(1'b0, 32'h4000_0003);
        issue(1'b1, 5'h0A, 5'h15, 16'h5A0F, "R8 write under attempted overwrite");
        repeat (100) @(posedge clk);
        reg_write(1'b1, {1'b1, 1'b0, 1'b0, 3'b000, 5'h1F, 5'h1F, 16'h1234});
        reg_read(1'b1, d);
        check(d == {3'b110, 3'b000, 5'h15, 5'h0A, 16'h5A0F}, "R8 register unchanged mid-frame",
              d, {3'b110, 3'b000, 5'h15, 5'h0A, 16'h5A0F});
        wait_cmd_done(d);
        check(d[15:0] == 16'h5A0F, "R8 data kept after frame", d[15:0], 16'h5A0F);
        repeat (40) @(posedge clk);
        check(!mdio_oe && !in_frame, "R8 no extra frame started", {in_frame, mdio_oe}, 2'b00);

        check(frames_seen == frames_pushed, "R4 frame count", frames_seen, frames_pushed);
        check(hold_viol == 0, "R5 output changes while MDC high", hold_viol, 0);
        finish_run();
    end
endmodule